// File: doc/BRIEF.md
# Three-Bit-Per-Clock Polynomial Remainder Divider

This block divides a binary message polynomial by the fixed generator G(y) = y^5 + y^3 + y + 1 over GF(2) and produces the 5-bit remainder, which serves as the check bits. Internally a one-bit shift-and-reduce recurrence is unrolled three times. Each clock therefore absorbs a 3-bit message word, where a plain serial divider would take one bit.

A sender presents the message as 3-bit words, highest-degree coefficient first, and flags the final word. The block divides the message shifted up by five positions. Its remainder therefore takes the place of five appended zeros and forms a codeword that G(y) divides exactly. A receiver feeds a whole codeword through the same block, and a zero remainder means no error was detected. Message lengths that are not a multiple of three are padded with leading zeros, which leave the remainder unchanged. A synchronous clear starts each new message.

Top module: `pdiv3_top`

## Requirements
- R1: While `clr` is high at a rising edge, the next cycle shows `rem_out` = 0 and `done` = 0, and the block again accepts words.
- R2: Each accepted word moves the remainder state by three serial steps, applied in the order `din[2]`, `din[1]`, `din[0]`. In each step the incoming bit is XORed with state bit 4, the state shifts up one place, and if that XOR is 1 the tap pattern 5'b01011 (y^0, y^1, y^3) is XORed in. The result equals (M(y)·y^5) mod G(y), with M(y) the concatenation of the words, first word most significant.
- R3: In a cycle with `din_valid` low and `clr` low, `rem_out` does not change.
- R4: A word accepted with `din_last` high makes `done` high for exactly the following cycle.
- R5: Once the last word has been accepted, `rem_out` holds its value, and further valid words have no effect until `clr`.
- R6: When `clr` and `din_valid` are both high at the same edge, the clear wins and the word is discarded.
- R7: A message followed by its own 5-bit remainder, padded with leading zeros to a multiple of 3 bits, divides to a remainder of 0.
- R8: Leading all-zero words do not change the final remainder.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| clr | input | 1 | Synchronous clear of remainder and status |
| din | input | 3 | Message word; bit 2 is the highest-degree coefficient |
| din_valid | input | 1 | Word on `din` is to be absorbed |
| din_last | input | 1 | Qualifies the valid word as the final one |
| rem_out | output | 5 | Current remainder (check bits), bit 4 = y^4 coefficient |
| done | output | 1 | One-cycle pulse after the last word is absorbed |

## Verification
Two things can land on the same edge: a clear and a valid word, which may also carry the last flag. The bench drives both together, both in the middle of a message and on its final word. It expects a zero remainder, no `done` pulse, and a clean start for the following message. A second overlap is a valid word that arrives while the result is being held after completion. The bench expects that word to leave the remainder untouched. A behavioural model judges every cycle. It keeps the message as an integer and reduces it by polynomial long division.

// File: rtl/pdiv_pkg.sv
package pdiv_pkg;
    localparam int             REM_W_DEF  = 5;
    localparam int             WORD_W_DEF = 3;
    // y^0, y^1, y^3 feedback points of y^5 + y^3 + y + 1
    localparam logic [4:0]     TAPS_DEF   = 5'b01011;
endpackage

// File: rtl/pdiv_step.sv
// One serial division step: absorb one message bit.
module pdiv_step #(
    parameter int             REM_W = 5,
    parameter logic [REM_W-1:0] TAPS = 5'b01011
) (
    input  logic [REM_W-1:0] r_i,
    input  logic             bit_i,
    output logic [REM_W-1:0] r_o
);
    logic fb;
    always_comb begin
        fb  = r_i[REM_W-1] ^ bit_i;
        r_o = {r_i[REM_W-2:0], 1'b0} ^ ({REM_W{fb}} & TAPS);
    end
endmodule

// File: rtl/pdiv_unfold.sv
// Chain of WORD_W serial steps; word MSB is absorbed first.
module pdiv_unfold #(
    parameter int             REM_W  = 5,
    parameter int             WORD_W = 3,
    parameter logic [REM_W-1:0] TAPS = 5'b01011
) (
    input  logic [REM_W-1:0]  r_i,
    input  logic [WORD_W-1:0] w_i,
    output logic [REM_W-1:0]  r_o
);
    logic [REM_W-1:0] chain [0:WORD_W];

    assign chain[0] = r_i;

    for (genvar k = 0; k < WORD_W; k++) begin : g_stage
        pdiv_step #(.REM_W(REM_W), .TAPS(TAPS)) u_step (
            .r_i   (chain[k]),
            .bit_i (w_i[WORD_W-1-k]),
            .r_o   (chain[k+1])
        );
    end

    assign r_o = chain[WORD_W];
endmodule

// File: rtl/pdiv3_top.sv
module pdiv3_top
    import pdiv_pkg::*;
#(
    parameter int               REM_W  = REM_W_DEF,
    parameter int               WORD_W = WORD_W_DEF,
    parameter logic [REM_W-1:0] TAPS   = TAPS_DEF
) (
    input  logic              clk,
    input  logic              clr,
    input  logic [WORD_W-1:0] din,
    input  logic              din_valid,
    input  logic              din_last,
    output logic [REM_W-1:0]  rem_out,
    output logic              done
);
    typedef struct packed {
        logic [REM_W-1:0] rem;
        logic             held;
        logic             done;
    } state_t;

    state_t           st_d, st_q;
    logic [REM_W-1:0] rem_next;

    pdiv_unfold #(.REM_W(REM_W), .WORD_W(WORD_W), .TAPS(TAPS)) u_unfold (
        .r_i (st_q.rem),
        .w_i (din),
        .r_o (rem_next)
    );

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        if (clr) begin
            st_d = '0;
        end else if (din_valid && !st_q.held) begin
            st_d.rem = rem_next;
            if (din_last) begin
                st_d.held = 1'b1;
                st_d.done = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign rem_out = st_q.rem;
    assign done    = st_q.done;
endmodule

// File: rtl/pdiv3_chk.sv
module pdiv3_chk #(
    parameter int REM_W  = 5,
    parameter int WORD_W = 3
) (
    input logic              clk,
    input logic              clr,
    input logic [WORD_W-1:0] din,
    input logic              din_valid,
    input logic              din_last,
    input logic [REM_W-1:0]  rem_out,
    input logic              done
);
    // R1: clear empties the remainder and kills done
    assert_clear_zero_R1: assert property (@(posedge clk)
        clr |=> (rem_out == '0 && !done));

    // R3: idle cycles keep the remainder
    assert_idle_hold_R3: assert property (@(posedge clk) disable iff (clr)
        !din_valid |=> $stable(rem_out));

    // R4: done is a single-cycle pulse
    assert_done_pulse_R4: assert property (@(posedge clk) disable iff (clr)
        done |=> !done);

    // R5: result frozen after completion
    assert_result_frozen_R5: assert property (@(posedge clk) disable iff (clr)
        done |=> $stable(rem_out));

    // R6: clear beats a simultaneous word
    assert_clear_wins_R6: assert property (@(posedge clk)
        (clr && din_valid) |=> (rem_out == '0 && !done));

    wire unused_ok = ^{din, din_last};
endmodule

bind pdiv3_top pdiv3_chk #(.REM_W(REM_W), .WORD_W(WORD_W)) u_chk (
    .clk       (clk),
    .clr       (clr),
    .din       (din),
    .din_valid (din_valid),
    .din_last  (din_last),
    .rem_out   (rem_out),
    .done      (done)
);

// File: tb/pdiv3_top_test.sv
module pdiv3_top_test;
    logic       clk = 1'b0;
    logic       clr = 1'b1;
    logic [2:0] din = '0;
    logic       din_valid = 1'b0;
    logic       din_last = 1'b0;
    logic [4:0] rem_out;
    logic       done;

    int n_vec = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;   // 125 MHz

    pdiv3_top uut (
        .clk(clk), .clr(clr), .din(din), .din_valid(din_valid),
        .din_last(din_last), .rem_out(rem_out), .done(done)
    );

    // y^5 + y^3 + y + 1
    localparam logic [63:0] GEN = 64'h2B;

    function automatic logic [4:0] polymod(input logic [63:0] v);
        for (int d = 63; d >= 5; d--)
            if (v[d]) v = v ^ (GEN << (d - 5));
        return v[4:0];
    endfunction

    // behavioural model: whole message held as an integer
    logic [63:0] m_msg  = '0;
    bit          m_held = 1'b0;
    bit          m_done = 1'b0;
    string       m_tag  = "R1";
    bit          m_live = 1'b0;

    always @(posedge clk) begin
        m_done = 1'b0;
        if (clr) begin
            m_msg = '0; m_held = 1'b0;
            m_tag = (din_valid) ? "R6" : "R1";
            m_live = 1'b1;
        end else if (din_valid && !m_held) begin
            m_msg = (m_msg << 3) | 64'(din);
            m_tag = "R2";
            if (din_last) begin m_held = 1'b1; m_done = 1'b1; m_tag = "R4"; end
        end else if (din_valid) begin
            m_tag = "R5";
        end else if (!m_held) begin
            m_tag = "R3";
        end
    end

    always @(posedge clk) begin
        #2;
        if (m_live && !finished) begin
            logic [4:0] er;
            er = polymod(m_msg << 5);
            n_vec++;
            if (rem_out !== er || done !== m_done) begin
                n_bad++;
                $display("FAIL %s: rem=%h done=%b expected rem=%h done=%b",
                         m_tag, rem_out, done, er, m_done);
            end
        end
    end

    task automatic cyc(input bit c, input bit v, input logic [2:0] w, input bit l);
        @(negedge clk);
        clr = c; din_valid = v; din = w; din_last = l;
    endtask

    task automatic check(input string tag, input logic [4:0] exp_v);
        @(negedge clk);
        n_vec++;
        if (rem_out !== exp_v) begin
            n_bad++;
            $display("FAIL %s: rem=%h expected %h", tag, rem_out, exp_v);
        end
    endtask

    // send bits (MSB of value at index nbits-1), padded to whole words
    task automatic send_bits(input logic [63:0] v, input int nbits, input bit gaps);
        int nw = (nbits + 2) / 3;
        for (int i = nw - 1; i >= 0; i--) begin
            if (gaps && ($urandom % 3 == 0)) cyc(0, 0, 3'($urandom), 0);
            cyc(0, 1, v[i*3 +: 3], i == 0);
        end
        cyc(0, 0, 0, 0);
    endtask

    initial begin
        repeat (3) cyc(1, 0, 0, 0);
        cyc(0, 0, 0, 0);
        check("R1", 5'h00);

        // R2/R3/R4: random messages with idle gaps
        for (int t = 0; t < 40; t++) begin
            int nw = 1 + ($urandom % 18);
            logic [63:0] v = {$urandom, $urandom};
            send_bits(v, nw * 3, 1'b1);
            // R5: words after completion are ignored
            repeat (3) cyc(0, 1, 3'($urandom), $urandom % 2);
            cyc(1, 0, 0, 0);
        end

        // R7: encode then re-divide the codeword
        for (int t = 0; t < 20; t++) begin
            int          nb = 4 + ($urandom % 40);
            logic [63:0] msg = {$urandom, $urandom} & ((64'd1 << nb) - 1);
            logic [4:0]  ck = polymod(msg << 5);
            logic [63:0] cw = (msg << 5) | 64'(ck);
            send_bits(msg, nb, 1'b0);
            check("R7 encode", ck);
            cyc(1, 0, 0, 0);
            send_bits(cw, nb + 5, 1'b1);
            check("R7", 5'h00);
            cyc(1, 0, 0, 0);
        end

        // R8: leading zero words
        begin
            logic [63:0] v = 64'h5A3C;
            send_bits(v, 18, 1'b0);
            check("R8", polymod(v << 5));
            cyc(1, 0, 0, 0);
            repeat (4) cyc(0, 1, 0, 0);
            send_bits(v, 18, 1'b0);
            check("R8", polymod(v << 5));
            cyc(1, 0, 0, 0);
        end

        // R6: clear together with a word, mid-message and on the last word
        cyc(0, 1, 3'b101, 0);
        cyc(0, 1, 3'b111, 0);
        cyc(1, 1, 3'b110, 0);
        cyc(0, 0, 0, 0);
        check("R6", 5'h00);
        cyc(0, 1, 3'b011, 0);
        cyc(1, 1, 3'b100, 1);
        cyc(0, 0, 0, 0);
        check("R6", 5'h00);
        send_bits(64'o4711, 12, 1'b0);
        check("R6 restart", polymod(64'o4711 << 5));

        repeat (2) cyc(0, 0, 0, 0);
        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        #1_000_000;
        if (!finished) begin
            finished = 1'b1;
            n_bad++;
            $display("FAIL watchdog: rem=%h expected completion", rem_out);
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end
endmodule